// File: doc/BRIEF.md
# LCD Row Scan and Polarity Sequencer

This block steps a dot-matrix LCD through its time slots. On every line tick it moves to the next slot. For that slot it gives the RAM row to fetch, the physical COM driver to energise, and a flag that marks the optional icon slot. It also drives the frame-polarity signal M. M toggles either once per frame or after a programmable number of lines. The line-count form is used to reduce crosstalk.

A command decoder elsewhere holds the configuration and feeds it in as static values. The configuration covers:
- the display start line;
- the COM0 offset;
- the multiplex count;
- the icon enable;
- the scan direction;
- the line-inversion code.

The same block turns one RAM bit into an on/off pixel level. To do so it applies the display-off, all-pixels-on and invert modes in a fixed order of priority. It also maps a segment driver index to a RAM column, taking segment reversal into account.

Top module: `lcd_row_sequencer`

## Requirements
- R1: For a panel slot s, `row_addr` equals (`start_line` + s) mod 64. The icon slot always reports `row_addr` = 64, whatever the start line is.
- R2: For a panel slot s, let c = (s + `com_offset`) mod 64. `com_idx` equals c when `scan_rev` = 0 and 63 − c when `scan_rev` = 1. On the icon slot `com_idx` is 0.
- R3: A `mux_code` from 16 to 64 sets that many panel slots. Any other value of `mux_code` behaves as 64.
- R4: When `icon_en` = 1, one extra slot follows the last panel slot. During that slot `icon_slot` = 1. At all other times `icon_slot` = 0.
- R5: After the last slot of a frame, the next line tick returns to slot 0.
- R6: When `ninv_code` = 0, `pol_m` toggles only on the line tick that wraps back to slot 0.
- R7: When `ninv_code` = k (1..31), `pol_m` toggles after every k+2 line ticks. This count runs on across frame boundaries without restarting.
- R8: `pix_on` follows these rules in order of priority:
  - it is 0 when `disp_on` = 0;
  - otherwise it is 1 when `all_on` = 1, including on the icon slot;
  - otherwise it is `pix_bit` XOR `invert` on panel slots, and plain `pix_bit` on the icon slot.
- R9: When `seg_rev` = 0, `col_addr` equals `seg_idx`. When `seg_rev` = 1, `col_addr` equals 95 − `seg_idx`.
- R10: After reset the block is in slot 0 with `pol_m` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_tick | input | 1 | Advance to the next slot |
| start_line | input | 6 | RAM row shown on the first slot |
| com_offset | input | 6 | Physical COM that the first slot drives |
| mux_code | input | 7 | Number of panel slots (16..64) |
| icon_en | input | 1 | Append the icon slot |
| scan_rev | input | 1 | Reverse the COM numbering |
| ninv_code | input | 5 | Line-inversion code; 0 means once per frame |
| disp_on | input | 1 | Display enable |
| all_on | input | 1 | Force all pixels on |
| invert | input | 1 | Invert panel pixels |
| pix_bit | input | 1 | RAM bit for the current pixel |
| seg_rev | input | 1 | Reverse the segment to column mapping |
| seg_idx | input | 7 | Segment driver index |
| row_addr | output | 7 | RAM row to fetch (64 = icon row) |
| com_idx | output | 6 | COM driver to energise |
| icon_slot | output | 1 | Current slot is the icon slot |
| pol_m | output | 1 | Drive polarity |
| pix_on | output | 1 | Resolved pixel level |
| col_addr | output | 7 | RAM column for `seg_idx` |

## Verification
A frame wrap and a line-inversion toggle can both fall on the same tick, so the two polarity rules meet there. The bench provokes this by setting the inversion span equal to the frame length: 16 panel slots with code 14 gives a span of 16 lines. It then checks two things. First, that M toggles exactly once on the wrapping tick and not twice. Second, that the next toggle comes a full span later. In the same way, the all-on and invert modes are driven together on both a panel slot and the icon slot, and the bench checks that all-on wins.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    localparam int ROWS    = 64;
    localparam int ROW_W   = $clog2(ROWS);
    localparam int SLOT_W  = ROW_W + 1;
    localparam int MUX_MIN = 16;
    localparam int COLS    = 96;
    localparam int COL_W   = $clog2(COLS);
    localparam int NINV_W  = 5;
    localparam int SPAN_W  = NINV_W + 1;
endpackage

// File: rtl/lrs_slot_ctr.sv
module lrs_slot_ctr
    import lrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic [SLOT_W-1:0] mux_code,
    input  logic              icon_en,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] eff_mux,
    output logic              frame_wrap
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } st_t;

    st_t st_d, st_q;
    logic [SLOT_W-1:0] last_slot;

    always_comb begin
        st_d = st_q;
        if (mux_code >= SLOT_W'(MUX_MIN) && mux_code <= SLOT_W'(ROWS))
            eff_mux = mux_code;
        else
            eff_mux = SLOT_W'(ROWS);
        last_slot  = eff_mux - SLOT_W'(1) + SLOT_W'(icon_en);
        frame_wrap = line_tick && (st_q.slot >= last_slot);
        if (line_tick)
            st_d.slot = frame_wrap ? '0 : st_q.slot + SLOT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot = st_q.slot;

    // R5
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (slot == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(slot));
endmodule

// File: rtl/lrs_polarity.sv
module lrs_polarity
    import lrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              frame_wrap,
    input  logic [NINV_W-1:0] ninv_code,
    output logic              pol_m
);
    typedef struct packed {
        logic              pol;
        logic [SPAN_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [SPAN_W-1:0] span;

    always_comb begin
        st_d = st_q;
        span = SPAN_W'(ninv_code) + SPAN_W'(2);
        if (line_tick) begin
            if (ninv_code == '0) begin
                st_d.cnt = '0;
                if (frame_wrap) st_d.pol = ~st_q.pol;
            end else if (st_q.cnt >= span - SPAN_W'(1)) begin
                st_d.cnt = '0;
                st_d.pol = ~st_q.pol;
            end else begin
                st_d.cnt = st_q.cnt + SPAN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pol_m = st_q.pol;

    // R6 R7
    pol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(pol_m));

    // R6
    frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && !frame_wrap && ninv_code == '0) |=> $stable(pol_m));
endmodule

// File: rtl/lrs_map.sv
module lrs_map
    import lrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOT_W-1:0] eff_mux,
    input  logic              icon_en,
    input  logic [ROW_W-1:0]  start_line,
    input  logic [ROW_W-1:0]  com_offset,
    input  logic              scan_rev,
    input  logic              disp_on,
    input  logic              all_on,
    input  logic              invert,
    input  logic              pix_bit,
    input  logic              seg_rev,
    input  logic [COL_W-1:0]  seg_idx,
    output logic [SLOT_W-1:0] row_addr,
    output logic [ROW_W-1:0]  com_idx,
    output logic              icon_slot,
    output logic              pix_on,
    output logic [COL_W-1:0]  col_addr
);
    logic [ROW_W-1:0] base_com;

    always_comb begin
        icon_slot = icon_en && (slot == eff_mux);
        base_com  = slot[ROW_W-1:0] + com_offset;
        if (icon_slot) begin
            row_addr = SLOT_W'(ROWS);
            com_idx  = '0;
        end else begin
            row_addr = {1'b0, slot[ROW_W-1:0] + start_line};
            com_idx  = scan_rev ? ROW_W'(ROWS - 1) - base_com : base_com;
        end
        if (!disp_on)       pix_on = 1'b0;
        else if (all_on)    pix_on = 1'b1;
        else if (icon_slot) pix_on = pix_bit;
        else                pix_on = pix_bit ^ invert;
        col_addr = seg_rev ? COL_W'(COLS - 1) - seg_idx : seg_idx;
    end

    // R8
    off_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |-> !pix_on);

    // R4
    icon_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        icon_slot |-> (row_addr == SLOT_W'(ROWS) && com_idx == '0));

    // R1
    panel_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !icon_slot |-> (row_addr < SLOT_W'(ROWS)));
endmodule

// File: rtl/lcd_row_sequencer.sv
module lcd_row_sequencer
    import lrs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_tick,
    input  logic [5:0]  start_line,
    input  logic [5:0]  com_offset,
    input  logic [6:0]  mux_code,
    input  logic        icon_en,
    input  logic        scan_rev,
    input  logic [4:0]  ninv_code,
    input  logic        disp_on,
    input  logic        all_on,
    input  logic        invert,
    input  logic        pix_bit,
    input  logic        seg_rev,
    input  logic [6:0]  seg_idx,
    output logic [6:0]  row_addr,
    output logic [5:0]  com_idx,
    output logic        icon_slot,
    output logic        pol_m,
    output logic        pix_on,
    output logic [6:0]  col_addr
);
    logic [SLOT_W-1:0] slot, eff_mux;
    logic              frame_wrap;

    lrs_slot_ctr u_slot (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
        .mux_code(mux_code), .icon_en(icon_en),
        .slot(slot), .eff_mux(eff_mux), .frame_wrap(frame_wrap)
    );

    lrs_polarity u_pol (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
        .frame_wrap(frame_wrap), .ninv_code(ninv_code), .pol_m(pol_m)
    );

    lrs_map u_map (
        .clk(clk), .rst_n(rst_n), .slot(slot), .eff_mux(eff_mux),
        .icon_en(icon_en), .start_line(start_line), .com_offset(com_offset),
        .scan_rev(scan_rev), .disp_on(disp_on), .all_on(all_on),
        .invert(invert), .pix_bit(pix_bit), .seg_rev(seg_rev),
        .seg_idx(seg_idx), .row_addr(row_addr), .com_idx(com_idx),
        .icon_slot(icon_slot), .pix_on(pix_on), .col_addr(col_addr)
    );
endmodule

// File: tb/lcd_row_sequencer_bench.sv
module lcd_row_sequencer_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_tick = 1'b0;
    logic [5:0] start_line = '0, com_offset = '0;
    logic [6:0] mux_code = 7'd64;
    logic icon_en = 1'b0, scan_rev = 1'b0;
    logic [4:0] ninv_code = '0;
    logic disp_on = 1'b1, all_on = 1'b0, invert = 1'b0, pix_bit = 1'b0;
    logic seg_rev = 1'b0;
    logic [6:0] seg_idx = '0;
    logic [6:0] row_addr;
    logic [5:0] com_idx;
    logic icon_slot, pol_m, pix_on;
    logic [6:0] col_addr;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    lcd_row_sequencer u_lcd_row_sequencer (.*);

    typedef struct packed {
        logic [5:0] st;
        logic [5:0] off;
        logic       rev;
        logic [6:0] mux;
        logic       icon;
        logic [6:0] steps;
        logic [6:0] e_row;
        logic [5:0] e_com;
        logic       e_icon;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{6'd0,  6'd0,  1'b0, 7'd64, 1'b0, 7'd0,  7'd0,  6'd0,  1'b0},
        '{6'd1,  6'd0,  1'b0, 7'd64, 1'b0, 7'd0,  7'd1,  6'd0,  1'b0},
        '{6'd48, 6'd0,  1'b0, 7'd64, 1'b0, 7'd20, 7'd4,  6'd20, 1'b0},
        '{6'd0,  6'd5,  1'b0, 7'd64, 1'b0, 7'd3,  7'd3,  6'd8,  1'b0},
        '{6'd0,  6'd5,  1'b1, 7'd64, 1'b0, 7'd3,  7'd3,  6'd55, 1'b0},
        '{6'd63, 6'd63, 1'b0, 7'd64, 1'b0, 7'd2,  7'd1,  6'd1,  1'b0},
        '{6'd10, 6'd0,  1'b0, 7'd16, 1'b1, 7'd16, 7'd64, 6'd0,  1'b1},
        '{6'd10, 6'd0,  1'b0, 7'd16, 1'b0, 7'd16, 7'd10, 6'd0,  1'b0},
        '{6'd0,  6'd0,  1'b0, 7'd10, 1'b0, 7'd16, 7'd16, 6'd16, 1'b0},
        '{6'd0,  6'd0,  1'b0, 7'd65, 1'b1, 7'd64, 7'd64, 6'd0,  1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        line_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            line_tick = 1'b1;
            @(negedge clk);
        end
        line_tick = 1'b0;
    endtask

    initial begin
        #3_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10 reset state
        do_reset();
        check("R10 row", row_addr, 0);
        check("R10 com", com_idx, 0);
        check("R10 pol", pol_m, 0);

        // R1 R2 R3 R4 R5 table walk
        for (int v = 0; v < NV; v++) begin
            start_line = VEC[v].st;
            com_offset = VEC[v].off;
            scan_rev   = VEC[v].rev;
            mux_code   = VEC[v].mux;
            icon_en    = VEC[v].icon;
            do_reset();
            step(int'(VEC[v].steps));
            check("R1 row", row_addr, int'(VEC[v].e_row));
            check("R2 com", com_idx, int'(VEC[v].e_com));
            check("R4 icon", icon_slot, int'(VEC[v].e_icon));
        end

        // R6 frame-rate polarity, 16 slots
        start_line = '0; com_offset = '0; scan_rev = 1'b0;
        mux_code = 7'd16; icon_en = 1'b0; ninv_code = '0;
        do_reset();
        step(15);
        check("R6 before wrap", pol_m, 0);
        step(1);
        check("R6 at wrap", pol_m, 1);
        check("R5 slot0 row", row_addr, 0);
        // R6 with icon: frame of 17
        icon_en = 1'b1;
        do_reset();
        step(16);
        check("R6 icon before wrap", pol_m, 0);
        step(1);
        check("R6 icon at wrap", pol_m, 1);

        // R7 three-line inversion
        icon_en = 1'b0; ninv_code = 5'd1;
        do_reset();
        step(2);
        check("R7 n3 early", pol_m, 0);
        step(1);
        check("R7 n3 toggle", pol_m, 1);
        step(3);
        check("R7 n3 second", pol_m, 0);

        // R7 span 5 runs across frame of 16
        ninv_code = 5'd3;
        do_reset();
        step(16);
        check("R7 across frame", pol_m, 1);
        step(4);
        check("R7 free count", pol_m, 0);

        // R6 R7 coincident wrap and span toggle (span 16 = frame 16)
        ninv_code = 5'd14;
        do_reset();
        step(16);
        check("R7 coincide pol", pol_m, 1);
        check("R5 coincide row", row_addr, 0);
        step(15);
        check("R7 coincide hold", pol_m, 1);
        step(1);
        check("R7 coincide next", pol_m, 0);

        // R8 pixel priority on a panel slot
        ninv_code = '0; mux_code = 7'd16; icon_en = 1'b1;
        do_reset();
        disp_on = 1'b0; all_on = 1'b1; invert = 1'b1; pix_bit = 1'b1;
        #1 check("R8 off wins", pix_on, 0);
        disp_on = 1'b1; pix_bit = 1'b0;
        #1 check("R8 all_on over invert", pix_on, 1);
        all_on = 1'b0; pix_bit = 1'b1;
        #1 check("R8 invert", pix_on, 0);
        invert = 1'b0;
        #1 check("R8 normal", pix_on, 1);
        // R8 icon slot
        step(16);
        check("R4 icon reached", icon_slot, 1);
        invert = 1'b1; pix_bit = 1'b1;
        #1 check("R8 icon ignores invert", pix_on, 1);
        all_on = 1'b1; pix_bit = 1'b0;
        #1 check("R8 icon all_on", pix_on, 1);
        all_on = 1'b0; invert = 1'b0;

        // R9 segment remap
        seg_rev = 1'b0; seg_idx = 7'd3;
        #1 check("R9 direct", col_addr, 3);
        seg_rev = 1'b1; seg_idx = 7'd0;
        #1 check("R9 rev first", col_addr, 95);
        seg_idx = 7'd95;
        #1 check("R9 rev last", col_addr, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule